// File: doc/BRIEF.md
# Realigning Packet Loader for a Tagged Transmit FIFO

This block fills a transmit FIFO whose entries are 36 bits wide: a 4-bit tag on top of a 32-bit payload. For each outgoing host transaction it first writes a start command word built from the endpoint, device address, speed, transfer type, data toggle and PID it was handed. It then takes the packet bytes from a stream of memory-aligned 32-bit words. The packet may begin at any byte lane of the first source word. The block shifts and merges those bytes into whole 32-bit payload words and writes only complete words as payload.

Every packet is closed by an end-of-packet word. That word carries any 1 to 3 leftover bytes, zero padded, together with their count. Writing it is the only way the byte-merging state returns to empty. The transaction engine can abort a packet with an underrun pulse. An aborted packet still goes through the end-of-packet step, so the aligner is always empty before the next start command is accepted, and that command enters the FIFO unshifted.

The command and source inputs are valid/ready streams. A transfer happens on any rising edge where both valid and ready are high. The FIFO side is a write strobe gated by a full flag. `fifo_full` is the only back-pressure the block receives. While it is high, nothing is written, no source word is consumed if it would complete a payload word, and no byte is lost.

Top module: `ldr_pkt_loader`

## Requirements
- R1: After reset, `fifo_wr` is 0, `cmd_ready` is 1 and `src_ready` is 0.
- R2: The first entry of each packet is a start command with tag 0x0 and payload bits 29:23 endpoint, 22:16 device address, 9:8 speed, 7:6 transfer type, 5:4 data toggle, 3:0 PID. Bits 31:30 and 15:10 are zero.
- R3: Payload entries carry tag 0x2. Packet byte k is placed in payload word k/4 at bits 8*(k%4)+7 down to 8*(k%4), and exactly floor(len/4) payload entries are written.
- R4: Packet byte 0 is taken from byte lane `cmd_offset` (0 to 3, lane n at bits 8n+7:8n) of the first source word. Later bytes follow in lane order across the following source words, and ceil((offset+len)/4) source words are consumed.
- R5: The last entry of a packet has tag 0x1. Its bits 25:24 hold len%4, bits 23:0 hold the leftover bytes in the same lane order with unused lanes zero, and bits 31:26 are zero.
- R6: A packet of length 0 writes only its start command and its end-of-packet entry, and consumes no source word.
- R7: An `underrun` pulse during the data phase stops source consumption at once. The next entry written is an end-of-packet word with bit 26 set and bits 25:0 zero, and `src_ready` stays low afterwards until a new packet's data phase.
- R8: After any end-of-packet entry, including an aborted one, the next packet's start command and payload are exactly as if the block had just left reset.
- R9: No entry is written while `fifo_full` is high, and the FIFO contents under back-pressure equal those written without it.
- R10: `cmd_ready` is high only between packets. While it is high, `fifo_wr` and `src_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Packet command offered |
| cmd_ready | output | 1 | Loader idle, command taken on this edge |
| cmd_ep | input | 7 | Endpoint number |
| cmd_dev | input | 7 | Device address |
| cmd_speed | input | 2 | Endpoint speed code |
| cmd_xtype | input | 2 | Transfer type code |
| cmd_toggle | input | 2 | Data toggle code |
| cmd_pid | input | 4 | Packet identifier |
| cmd_offset | input | 2 | Byte lane of packet byte 0 in the first source word |
| cmd_len | input | LEN_W | Packet length in bytes |
| src_valid | input | 1 | Source word offered |
| src_ready | output | 1 | Source word consumed on this edge |
| src_data | input | 32 | Memory-aligned source word, lane n at bits 8n+7:8n |
| underrun | input | 1 | Abort pulse from the transaction engine |
| fifo_full | input | 1 | FIFO cannot take an entry this cycle |
| fifo_wr | output | 1 | Write strobe, never high while full |
| fifo_wdata | output | 36 | Entry: tag in 35:32, payload in 31:0 |

## Verification
The assertions assume that the source supplies exactly ceil((offset+len)/4) words per packet, and fewer only when the packet is aborted. They also assume that `underrun` is pulsed only while the packet is in its data phase, and that `fifo_full` may change on any cycle. The stimulus keeps to this. Each scenario feeds precisely the word count its offset and length call for. The abort scenario stops the source after two words and pulses the abort once, while the loader still waits for bytes. A stalling pattern on `fifo_full` is applied only as a free-running input, which the block must tolerate in any phase.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned TAG_W   = 4;
  localparam int unsigned ENTRY_W = TAG_W + WORD_W;
  localparam int unsigned LANES   = WORD_W / 8;
  localparam int unsigned RESID_W = WORD_W - 8;

  localparam logic [TAG_W-1:0] TAG_SOP  = 4'h0;
  localparam logic [TAG_W-1:0] TAG_EOP  = 4'h1;
  localparam logic [TAG_W-1:0] TAG_DATA = 4'h2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SOP  = 2'd1,
    ST_DATA = 2'd2,
    ST_EOP  = 2'd3
  } ldr_state_e;

  typedef struct packed {
    logic [6:0] ep;
    logic [6:0] dev;
    logic [1:0] speed;
    logic [1:0] xtype;
    logic [1:0] toggle;
    logic [3:0] pid;
  } sop_fields_t;

  // start command payload; field positions are decoded downstream
  function automatic logic [WORD_W-1:0] pack_sop(input sop_fields_t f);
    return {2'b00, f.ep, f.dev, 6'b000000, f.speed, f.xtype, f.toggle, f.pid};
  endfunction

  // end-of-packet payload: abort flag, leftover count, leftover bytes
  function automatic logic [WORD_W-1:0] pack_eop(input logic ab,
                                                input logic [1:0] cnt,
                                                input logic [RESID_W-1:0] res);
    return {5'b00000, ab, cnt, res};
  endfunction
endpackage

// File: rtl/ldr_align.sv
module ldr_align
  import ldr_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [1:0]         ld_off,
  input  logic [LEN_W-1:0]   ld_len,
  input  logic               act,
  input  logic               clear,
  input  logic               src_valid,
  input  logic [WORD_W-1:0]  src_data,
  input  logic               fifo_full,
  output logic               src_ready,
  output logic               emit,
  output logic [WORD_W-1:0]  emit_data,
  output logic               rem_zero,
  output logic [RESID_W-1:0] hold_bytes,
  output logic [1:0]         hold_cnt
);
  localparam int unsigned MERGE_W = WORD_W + RESID_W;

  logic               first_q;
  logic [1:0]         off_q;
  logic [LEN_W-1:0]   rem_q;
  logic [RESID_W-1:0] hold_q;
  logic [1:0]         hcnt_q;

  logic [2:0]         start_lane;
  logic [2:0]         avail;
  logic [LEN_W-1:0]   avail_l;
  logic [2:0]         nb;
  logic [2:0]         total;
  logic [WORD_W-1:0]  shifted;
  logic [WORD_W-1:0]  lane_mask;
  logic [WORD_W-1:0]  picked;
  logic [MERGE_W-1:0] merged;
  logic               full_word;
  logic               fire;

  always_comb begin
    start_lane = first_q ? {1'b0, off_q} : 3'd0;
    avail      = 3'd4 - start_lane;
    avail_l    = LEN_W'(avail);
    nb         = (rem_q < avail_l) ? rem_q[2:0] : avail;
    shifted    = src_data >> {start_lane, 3'b000};
    case (nb)
      3'd0:    lane_mask = '0;
      3'd1:    lane_mask = 32'h0000_00FF;
      3'd2:    lane_mask = 32'h0000_FFFF;
      3'd3:    lane_mask = 32'h00FF_FFFF;
      default: lane_mask = '1;
    endcase
    picked    = shifted & lane_mask;
    merged    = {{WORD_W{1'b0}}, hold_q} | ({{RESID_W{1'b0}}, picked} << {hcnt_q, 3'b000});
    total     = {1'b0, hcnt_q} + nb;
    full_word = total[2];
  end

  assign rem_zero   = (rem_q == '0);
  assign src_ready  = act && !rem_zero && (!full_word || !fifo_full);
  assign fire       = src_valid && src_ready;
  assign emit       = fire && full_word;
  assign emit_data  = merged[WORD_W-1:0];
  assign hold_bytes = hold_q;
  assign hold_cnt   = hcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      off_q   <= '0;
      rem_q   <= '0;
      hold_q  <= '0;
      hcnt_q  <= '0;
    end else if (load) begin
      first_q <= 1'b1;
      off_q   <= ld_off;
      rem_q   <= ld_len;
      hold_q  <= '0;
      hcnt_q  <= '0;
    end else if (clear) begin
      first_q <= 1'b0;
      rem_q   <= '0;
      hold_q  <= '0;
      hcnt_q  <= '0;
    end else if (fire) begin
      first_q <= 1'b0;
      rem_q   <= rem_q - LEN_W'(nb);
      hcnt_q  <= total[1:0];
      hold_q  <= full_word ? merged[MERGE_W-1:WORD_W] : merged[RESID_W-1:0];
    end
  end

  // R4
  one_word_per_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (rem_q == $past(rem_q) - LEN_W'($past(nb))));

  // R3
  hold_tidy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt_q == 2'd0) |-> (hold_q == '0));
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic fifo_full,
  input  logic underrun,
  input  logic rem_zero,
  output logic cmd_ready,
  output logic load,
  output logic act,
  output logic data_phase,
  output logic sop_wr,
  output logic eop_wr,
  output logic aborted
);
  ldr_state_e st_q, st_d;
  logic       abort_q, abort_d;

  assign cmd_ready  = (st_q == ST_IDLE);
  assign load       = cmd_ready && cmd_valid;
  assign data_phase = (st_q == ST_DATA);
  assign act        = data_phase && !underrun;
  assign sop_wr     = (st_q == ST_SOP) && !fifo_full;
  assign eop_wr     = (st_q == ST_EOP) && !fifo_full;
  assign aborted    = abort_q;

  always_comb begin
    st_d    = st_q;
    abort_d = abort_q;
    case (st_q)
      ST_IDLE: if (cmd_valid) st_d = ST_SOP;
      ST_SOP:  if (!fifo_full) st_d = ST_DATA;
      ST_DATA: begin
        if (underrun) begin
          st_d    = ST_EOP;
          abort_d = 1'b1;
        end else if (rem_zero) begin
          st_d = ST_EOP;
        end
      end
      default: if (!fifo_full) begin
        st_d    = ST_IDLE;
        abort_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      abort_q <= abort_d;
    end
  end

  // R8
  eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_wr |=> (cmd_ready && !aborted));

  // R10
  cmd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !cmd_ready);
endmodule

// File: rtl/ldr_fmt.sv
module ldr_fmt
  import ldr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  sop_fields_t        fields,
  input  logic               sop_wr,
  input  logic               eop_wr,
  input  logic               emit,
  input  logic [WORD_W-1:0]  emit_data,
  input  logic               aborted,
  input  logic [RESID_W-1:0] hold_bytes,
  input  logic [1:0]         hold_cnt,
  output logic               fifo_wr,
  output logic [ENTRY_W-1:0] fifo_wdata
);
  logic [WORD_W-1:0] sop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sop_q <= '0;
    else if (load) sop_q <= pack_sop(fields);
  end

  assign fifo_wr = sop_wr || eop_wr || emit;

  always_comb begin
    if (sop_wr)
      fifo_wdata = {TAG_SOP, sop_q};
    else if (eop_wr)
      fifo_wdata = {TAG_EOP, pack_eop(aborted,
                                      aborted ? 2'd0 : hold_cnt,
                                      aborted ? '0 : hold_bytes)};
    else
      fifo_wdata = {TAG_DATA, emit_data};
  end

  // R10
  one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sop_wr, eop_wr, emit}));

  // R2
  sop_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[35:32] == TAG_SOP) |-> (fifo_wdata[31:30] == 2'b00 && fifo_wdata[15:10] == 6'd0));

  // R5
  eop_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[35:32] == TAG_EOP) |-> (fifo_wdata[31:27] == 5'd0));

  // R7
  abort_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[35:32] == TAG_EOP && fifo_wdata[26]) |-> (fifo_wdata[25:0] == 26'd0));
endmodule

// File: rtl/ldr_pkt_loader.sv
module ldr_pkt_loader
  import ldr_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [6:0]       cmd_ep,
  input  logic [6:0]       cmd_dev,
  input  logic [1:0]       cmd_speed,
  input  logic [1:0]       cmd_xtype,
  input  logic [1:0]       cmd_toggle,
  input  logic [3:0]       cmd_pid,
  input  logic [1:0]       cmd_offset,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [31:0]      src_data,
  input  logic             underrun,
  input  logic             fifo_full,
  output logic             fifo_wr,
  output logic [35:0]      fifo_wdata
);
  logic               load, act, data_phase, sop_wr, eop_wr, aborted;
  logic               emit, rem_zero;
  logic [WORD_W-1:0]  emit_data;
  logic [RESID_W-1:0] hold_bytes;
  logic [1:0]         hold_cnt;
  sop_fields_t        fields;

  assign fields = '{ep: cmd_ep, dev: cmd_dev, speed: cmd_speed,
                    xtype: cmd_xtype, toggle: cmd_toggle, pid: cmd_pid};

  ldr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .fifo_full(fifo_full),
    .underrun(underrun), .rem_zero(rem_zero), .cmd_ready(cmd_ready),
    .load(load), .act(act), .data_phase(data_phase), .sop_wr(sop_wr),
    .eop_wr(eop_wr), .aborted(aborted)
  );

  ldr_align #(.LEN_W(LEN_W)) u_align (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_off(cmd_offset),
    .ld_len(cmd_len), .act(act), .clear(eop_wr), .src_valid(src_valid),
    .src_data(src_data), .fifo_full(fifo_full), .src_ready(src_ready),
    .emit(emit), .emit_data(emit_data), .rem_zero(rem_zero),
    .hold_bytes(hold_bytes), .hold_cnt(hold_cnt)
  );

  ldr_fmt u_fmt (
    .clk(clk), .rst_n(rst_n), .load(load), .fields(fields),
    .sop_wr(sop_wr), .eop_wr(eop_wr), .emit(emit), .emit_data(emit_data),
    .aborted(aborted), .hold_bytes(hold_bytes), .hold_cnt(hold_cnt),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
  );

  // R9
  no_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!fifo_wr && !src_ready));

  // R8
  eop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_wdata[35:32] == TAG_EOP) |=> (hold_cnt == 2'd0));

  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && data_phase) |=> !src_ready);
endmodule

// File: tb/sim_ldr_pkt_loader.sv
`timescale 1ns/1ps
module sim_ldr_pkt_loader;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [6:0] cmd_ep = '0, cmd_dev = '0;
  logic [1:0] cmd_speed = '0, cmd_xtype = '0, cmd_toggle = '0, cmd_offset = '0;
  logic [3:0] cmd_pid = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic src_valid = 1'b0;
  logic src_ready;
  logic [31:0] src_data = '0;
  logic underrun = 1'b0;
  logic fifo_full = 1'b0;
  logic fifo_wr;
  logic [35:0] fifo_wdata;

  int n_checks = 0;
  int n_fail = 0;
  logic [35:0] cap [0:63];
  int cap_n = 0;
  bit full_en = 1'b0;
  bit wr_full_seen = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  ldr_pkt_loader #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_ep(cmd_ep), .cmd_dev(cmd_dev), .cmd_speed(cmd_speed),
    .cmd_xtype(cmd_xtype), .cmd_toggle(cmd_toggle), .cmd_pid(cmd_pid),
    .cmd_offset(cmd_offset), .cmd_len(cmd_len), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .underrun(underrun),
    .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata)
  );

  // capture every accepted FIFO write, sampled mid-cycle
  always @(negedge clk) begin
    if (fifo_wr && fifo_full) wr_full_seen = 1'b1;
    if (fifo_wr && !fifo_full && cap_n < 64) begin
      cap[cap_n] = fifo_wdata;
      cap_n = cap_n + 1;
    end
  end

  // back-pressure pattern, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc = cyc + 1;
      fifo_full = full_en && ((cyc % 3) != 0);
    end
  end

  function automatic logic [7:0] mb(input int seed, input int p);
    return 8'((seed * 7 + p * 13 + 1) & 255);
  endfunction

  function automatic logic [31:0] mw(input int seed, input int i);
    return {mb(seed, 4*i+3), mb(seed, 4*i+2), mb(seed, 4*i+1), mb(seed, 4*i)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] got, input logic [35:0] exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue_cmd(input logic [6:0] ep, input logic [6:0] dev, input logic [3:0] pid,
                           input int off, input int len);
    @(posedge clk);
    #1;
    cmd_valid = 1'b1;
    cmd_ep = ep; cmd_dev = dev; cmd_pid = pid;
    cmd_speed = pid[1:0]; cmd_xtype = ep[1:0]; cmd_toggle = dev[1:0];
    cmd_offset = 2'(off); cmd_len = LEN_W'(len);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic feed(input int seed, input int nw);
    for (int i = 0; i < nw; i++) begin
      #1;
      src_valid = 1'b1;
      src_data = mw(seed, i);
      do @(negedge clk); while (!src_ready);
      @(posedge clk);
    end
    #1;
    src_valid = 1'b0;
  endtask

  task automatic wait_eop();
    int t;
    t = 0;
    while (!(cap_n > 0 && cap[cap_n-1][35:32] == 4'h1) && t < 600) begin
      @(negedge clk);
      t++;
    end
    check(t < 600, "R5 end entry seen", 36'(cap_n), 36'd0);
  endtask

  task automatic do_packet(input int seed, input int off, input int len,
                           input logic [6:0] ep, input logic [6:0] dev,
                           input logic [3:0] pid, input string rq);
    int nw, nf, r;
    logic [35:0] e;
    logic [23:0] res;
    cap_n = 0;
    nw = (len == 0) ? 0 : (off + len + 3) / 4;
    fork
      issue_cmd(ep, dev, pid, off, len);
      feed(seed, nw);
    join
    wait_eop();
    repeat (3) @(negedge clk);
    nf = len / 4;
    r = len % 4;
    check(cap_n == nf + 2, {rq, " entry count"}, 36'(cap_n), 36'(nf + 2));
    e = {4'h0, 2'b00, ep, dev, 6'd0, pid[1:0], ep[1:0], dev[1:0], pid};
    check(cap[0] === e, {rq, " R2 start command"}, cap[0], e);
    for (int j = 0; j < nf; j++) begin
      e = {4'h2, mb(seed, off+4*j+3), mb(seed, off+4*j+2), mb(seed, off+4*j+1), mb(seed, off+4*j)};
      check(cap[j+1] === e, {rq, " R3 payload word"}, cap[j+1], e);
    end
    res = '0;
    for (int k = 0; k < r; k++) res[8*k +: 8] = mb(seed, off + 4*nf + k);
    e = {4'h1, 5'd0, 1'b0, 2'(r), res};
    check(cap[nf+1] === e, {rq, " R5 end word"}, cap[nf+1], e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(fifo_wr == 1'b0, "R1 fifo_wr", 36'(fifo_wr), 36'd0);
    check(cmd_ready == 1'b1, "R1 cmd_ready", 36'(cmd_ready), 36'd1);
    check(src_ready == 1'b0, "R1 src_ready", 36'(src_ready), 36'd0);
  endtask

  task automatic t_aligned();
    do_packet(3, 0, 8, 7'h15, 7'h2A, 4'h1, "R3 aligned");
  endtask

  task automatic t_offsets();
    do_packet(5, 1, 7, 7'h7F, 7'h01, 4'hE, "R4 lane1");
    do_packet(9, 2, 5, 7'h40, 7'h7E, 4'h9, "R4 lane2");
    do_packet(11, 3, 13, 7'h03, 7'h55, 4'h6, "R4 lane3");
  endtask

  task automatic t_zero_len();
    do_packet(2, 2, 0, 7'h11, 7'h22, 4'h3, "R6 empty");
  endtask

  task automatic t_backpressure();
    wr_full_seen = 1'b0;
    full_en = 1'b1;
    do_packet(17, 3, 17, 7'h5A, 7'h33, 4'hB, "R9 stalled");
    full_en = 1'b0;
    check(!wr_full_seen, "R9 write while full", 36'(wr_full_seen), 36'd0);
  endtask

  task automatic t_abort();
    logic [35:0] e;
    cap_n = 0;
    fork
      issue_cmd(7'h0C, 7'h44, 4'h1, 1, 20);
      feed(21, 2);
    join
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b0, "R10 busy mid-packet", 36'(cmd_ready), 36'd0);
    @(posedge clk); #1; underrun = 1'b1;
    @(posedge clk); #1; underrun = 1'b0;
    src_valid = 1'b1;
    src_data = mw(21, 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(src_ready == 1'b0, "R7 source halted", 36'(src_ready), 36'd0);
    end
    #1 src_valid = 1'b0;
    wait_eop();
    check(cap_n == 3, "R7 entry count", 36'(cap_n), 36'd3);
    e = {4'h2, mb(21, 4), mb(21, 3), mb(21, 2), mb(21, 1)};
    check(cap[1] === e, "R7 word before abort", cap[1], e);
    check(cap[2] === 36'h1_0400_0000, "R7 abort end word", cap[2], 36'h1_0400_0000);
  endtask

  task automatic t_after_abort();
    do_packet(30, 0, 6, 7'h66, 7'h19, 4'hD, "R8 after abort");
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks = n_checks + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_aligned();
    t_offsets();
    t_zero_len();
    t_backpressure();
    t_abort();
    t_after_abort();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule